// File: doc/BRIEF.md
# Flash self-programming controller

This block is the control and status register that a CPU uses to start self-programming operations on its own flash. Software writes a command code into the low five bits of the register and then runs a store-to-program-memory instruction. The core reports that instruction on a one-cycle execute strobe. A command is armed only for a short window after the register write. If the strobe arrives inside the window, the block starts the operation. Otherwise the command bits clear themselves.

There are four operations: a temporary page-buffer load, a page erase, a page write and a lock-bit write. A buffer load is a one-cycle request and does not stop the CPU. The other three hold a request to the flash array, assert the CPU halt line and report busy until the array signals completion. Throughout that time the enable bit reads as set, so software can poll it.

A page erase or page write blocks reads of the application section. The block keeps that section blocked, and shows it in a status bit, until software runs a dedicated re-enable command. While the section is blocked, every application-section read request is refused.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00, no request is driven, `busy_o` and `cpu_halt_o` are low, and application reads are granted.
- R2: A register write stores bits 4:0 as the command field. The read value places the command in bits 4:0 and the blocked status in bit 6. Bits 5 and 7 read 0.
- R3: Only these command codes are accepted: 00001 (buffer load), 00011 (page erase), 00101 (page write), 01001 (lock-bit write) and 10001 (application re-enable). For any other code an execute strobe starts nothing, and the command field clears when the window ends.
- R4: A register write at clock edge k arms the command. An execute strobe sampled at edge k+1, k+2, k+3 or k+4 is accepted. With no accepted strobe, the command field reads 0 after edge k+4, and later strobes are ignored.
- R5: An accepted buffer load drives `req_load_o` high for exactly the one cycle after the accepting edge. It does not raise busy or halt, and it clears the command field.
- R6: An accepted erase, write or lock command asserts its request, `busy_o` and `cpu_halt_o` from the accepting edge onward. Bit 0 reads 1 while busy. The edge at which `flash_done_i` is high drops all three and clears the command field.
- R7: Register writes made while `busy_o` is high leave the register unchanged.
- R8: An accepted page erase or page write sets the blocked status bit. While that bit is set, `app_rd_grant_o` stays low even when `app_rd_req_i` is high. A lock-bit write does not set the bit.
- R9: An accepted re-enable command clears the blocked status bit and the command field. It issues no request, and it raises neither busy nor halt.
- R10: An execute strobe with no armed command has no effect on the register, the requests or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 8 | Register write data |
| csr_rdata_o | output | 8 | Register read value |
| spm_exec_i | input | 1 | Store-to-program-memory execute strobe |
| flash_done_i | input | 1 | Flash array reports that the running operation has finished |
| req_load_o | output | 1 | Temporary-buffer load request (one-cycle pulse) |
| req_erase_o | output | 1 | Page-erase request (level) |
| req_write_o | output | 1 | Page-write request (level) |
| req_lock_o | output | 1 | Lock-bit-write request (level) |
| cpu_halt_o | output | 1 | Halts the CPU during long operations |
| busy_o | output | 1 | An operation is in progress |
| app_rd_req_i | input | 1 | A read of the application section is requested |
| app_rd_grant_o | output | 1 | That read is allowed |

## Verification
The assertions assume that `flash_done_i` is only meaningful while `busy_o` is high and is ignored otherwise. They also assume that the CPU, being halted, issues no execute strobe during a long operation. The stimulus holds to this. It raises `flash_done_i` only after the busy state has been observed. It asserts `spm_exec_i` only as a single-cycle pulse, and only outside any cycle that also carries a register write. The write-while-busy case is driven on purpose so that R7 is covered.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  localparam int CMD_W = 5;
  localparam int CSR_W = 8;
  localparam int BLK_BIT = 6;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_ERASE, OP_WRITE, OP_LOCK, OP_REEN
  } op_e;

  function automatic op_e decode_op(input logic [CMD_W-1:0] c);
    case (c)
      5'b00001: decode_op = OP_LOAD;
      5'b00011: decode_op = OP_ERASE;
      5'b00101: decode_op = OP_WRITE;
      5'b01001: decode_op = OP_LOCK;
      5'b10001: decode_op = OP_REEN;
      default:  decode_op = OP_NONE;
    endcase
  endfunction

  function automatic logic is_long(input op_e o);
    is_long = (o == OP_ERASE) || (o == OP_WRITE) || (o == OP_LOCK);
  endfunction
endpackage

// File: rtl/selfprog_window.sv
module selfprog_window #(
  parameter int WINDOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  output logic armed_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (arm_i)         cnt_q <= CNT_MAX;
    else if (cancel_i)      cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign armed_o = (cnt_q != '0);
  assign last_o  = (cnt_q == CNT_W'(1));

  // R4: window closes after its last cycle unless re-armed
  assert_window_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !arm_i) |=> !armed_o);
  assert_arm_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_o);
endmodule

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  input  logic done_i,
  output logic busy_o,
  output op_e  run_op_o,
  output logic load_pulse_o,
  output logic finish_o
);
  logic busy_q, load_q;
  op_e  run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= OP_NONE;
      load_q <= 1'b0;
    end else begin
      load_q <= start_i && (op_i == OP_LOAD);
      if (start_i && is_long(op_i)) begin
        busy_q <= 1'b1;
        run_q  <= op_i;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
        run_q  <= OP_NONE;
      end
    end
  end

  assign busy_o       = busy_q;
  assign run_op_o     = run_q;
  assign load_pulse_o = load_q;
  assign finish_o     = busy_q && done_i;

  // R5: a load request lasts one cycle
  assert_load_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);
  // R6: completion ends the operation
  assert_done_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q);
  assert_busy_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (busy_q && $stable(run_q)));
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  input  logic             spm_exec_i,
  input  logic             flash_done_i,
  output logic             req_load_o,
  output logic             req_erase_o,
  output logic             req_write_o,
  output logic             req_lock_o,
  output logic             cpu_halt_o,
  output logic             busy_o,
  input  logic             app_rd_req_i,
  output logic             app_rd_grant_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             blk_q;
  logic             busy, armed, last, finish, load_pulse;
  logic             wr_ok, accept, expire;
  op_e              cur_op, run_op;

  assign cur_op = decode_op(cmd_q);
  assign wr_ok  = csr_we_i && !busy;
  // a write in the same cycle as the strobe wins
  assign accept = armed && spm_exec_i && !busy && !csr_we_i && (cur_op != OP_NONE);
  assign expire = last && !accept && !wr_ok;

  selfprog_window #(.WINDOW(WINDOW)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (wr_ok),
    .cancel_i (accept),
    .armed_o  (armed),
    .last_o   (last)
  );

  selfprog_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .op_i         (cur_op),
    .done_i       (flash_done_i),
    .busy_o       (busy),
    .run_op_o     (run_op),
    .load_pulse_o (load_pulse),
    .finish_o     (finish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            cmd_q <= '0;
    else if (wr_ok)                                         cmd_q <= csr_wdata_i[CMD_W-1:0];
    else if (accept && (cur_op == OP_LOAD || cur_op == OP_REEN)) cmd_q <= '0;
    else if (finish || expire)                              cmd_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blk_q <= 1'b0;
    else if (accept && (cur_op == OP_ERASE || cur_op == OP_WRITE)) blk_q <= 1'b1;
    else if (accept && cur_op == OP_REEN) blk_q <= 1'b0;
  end

  always_comb begin
    csr_rdata_o = '0;
    csr_rdata_o[CMD_W-1:0] = cmd_q;
    csr_rdata_o[BLK_BIT]   = blk_q;
  end

  assign req_load_o     = load_pulse;
  assign req_erase_o    = busy && (run_op == OP_ERASE);
  assign req_write_o    = busy && (run_op == OP_WRITE);
  assign req_lock_o     = busy && (run_op == OP_LOCK);
  assign cpu_halt_o     = busy;
  assign busy_o         = busy;
  assign app_rd_grant_o = app_rd_req_i && !blk_q;

  // R6: enable bit stays set while busy
  assert_enable_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> cmd_q[0]);
  assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && flash_done_i) |=> (cmd_q == '0));
  // R7: writes ignored while busy
  assert_busy_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && busy && !flash_done_i) |=> $stable(cmd_q));
  // R4: expired window clears the command
  assert_expire_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (cmd_q == '0));
  // R8: erase or write implies blocked section
  assert_blocked_in_erase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_erase_o || req_write_o) |-> !app_rd_grant_o);
  assert_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_load_o, req_erase_o, req_write_o, req_lock_o}));
  // R10: strobe without armed command starts nothing
  assert_unarmed_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !csr_we_i && !busy) |=> (!busy && !req_load_o));
endmodule

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] csr_rdata;
  logic       spm = 1'b0, fdone = 1'b0, rd_req = 1'b0;
  logic       r_load, r_erase, r_write, r_lock, halt, busy, rd_grant;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  selfprog_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .spm_exec_i(spm), .flash_done_i(fdone),
    .req_load_o(r_load), .req_erase_o(r_erase), .req_write_o(r_write),
    .req_lock_o(r_lock), .cpu_halt_o(halt), .busy_o(busy),
    .app_rd_req_i(rd_req), .app_rd_grant_o(rd_grant)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d; tick(); csr_we = 1'b0;
  endtask

  // strobe after 'gap' idle cycles; expected op code pushed for the monitor
  task automatic exec(input int gap, input int exp_op);
    repeat (gap) tick();
    if (exp_op != 0) exp_q.push_back(exp_op);
    spm = 1'b1; tick(); spm = 1'b0;
  endtask

  task automatic finish_op();
    tick(); fdone = 1'b1; tick(); fdone = 1'b0;
  endtask

  // monitor: events 1 load, 2 erase, 3 write, 4 lock
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      int ev;
      ev = 0;
      if (r_load) ev = 1;
      else if (busy && !prev_busy) ev = r_erase ? 2 : r_write ? 3 : r_lock ? 4 : 9;
      if (ev != 0) begin
        if (exp_q.size() == 0) chk("R3 unexpected request", ev, 0);
        else chk("R3 request kind", ev, exp_q.pop_front());
      end
      prev_busy = busy;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rd_req = 1'b1;
    #23 rst_n = 1'b1;
    tick();
    // R1
    chk("R1 rdata", csr_rdata, 8'h00);
    chk("R1 busy/halt", {busy, halt}, 0);
    chk("R1 requests", {r_load, r_erase, r_write, r_lock}, 0);
    chk("R1 grant", rd_grant, 1);

    // R2: write stored, bits 7:5 of write data not stored
    wr(8'hE5);
    chk("R2 readback", csr_rdata, 8'h05);
    repeat (4) tick();
    chk("R4 expired clear", csr_rdata, 8'h00);

    // R5: buffer load
    wr(8'h01);
    exec(0, 1);
    chk("R5 load pulse", r_load, 1);
    chk("R5 no halt", {busy, halt}, 0);
    chk("R5 cmd cleared", csr_rdata, 8'h00);
    tick();
    chk("R5 pulse ends", r_load, 0);

    // R3: invalid code 00111
    wr(8'h07);
    exec(0, 0);
    chk("R3 invalid no busy", busy, 0);
    chk("R3 invalid held", csr_rdata, 8'h07);
    repeat (3) tick();
    chk("R3 invalid cleared", csr_rdata, 8'h00);

    // R4: strobe at last window edge (k+4) accepted: page erase
    wr(8'h03);
    exec(3, 2);
    chk("R6 erase busy/halt/req", {busy, halt, r_erase}, 3'b111);
    chk("R6 enable while busy", csr_rdata[0], 1);
    chk("R8 blocked status", csr_rdata[6], 1);
    chk("R8 read refused", rd_grant, 0);
    // R7: write while busy ignored
    wr(8'h00);
    chk("R7 write ignored", csr_rdata, 8'h43);
    finish_op();
    chk("R6 released", {busy, halt, r_erase}, 0);
    chk("R6 cmd cleared", csr_rdata, 8'h40);
    chk("R8 still blocked", rd_grant, 0);

    // R4: strobe one cycle late (k+5) rejected
    wr(8'h05);
    exec(4, 0);
    chk("R4 late rejected", busy, 0);
    chk("R4 late cmd clear", csr_rdata, 8'h40);

    // page write at k+2
    wr(8'h05);
    exec(1, 3);
    chk("R6 write req", {busy, r_write, halt}, 3'b111);
    repeat (3) tick();
    chk("R6 write held", r_write, 1);
    finish_op();
    chk("R6 write done", {busy, r_write}, 0);

    // R9: re-enable
    wr(8'h11);
    exec(0, 0);
    chk("R9 status cleared", csr_rdata, 8'h00);
    chk("R9 no busy", {busy, halt}, 0);
    chk("R9 grant back", rd_grant, 1);

    // lock-bit write does not block (R8)
    wr(8'h09);
    exec(2, 4);
    chk("R6 lock req", {busy, r_lock}, 2'b11);
    chk("R8 lock no block", csr_rdata[6], 0);
    finish_op();
    chk("R6 lock done", {busy, csr_rdata}, 0);

    // R10: strobe with nothing armed
    repeat (2) tick();
    exec(0, 0);
    tick();
    chk("R10 unarmed", {busy, r_load, csr_rdata}, 0);

    repeat (3) tick();
    chk("R3 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule